// File: doc/BRIEF.md
# Dual-Threshold Switched-Capacitor Phase Controller

This block sequences the power switches of a step-down switched-capacitor converter built from one direct source switch and two conversion blocks that take turns feeding the load. It watches two comparator flags on the converter output. The upper flag means the output is above the target threshold. The lower flag means the output is above the minimum threshold. From these flags it drives three switch enables: direct, block 1 and block 2.

The output first charges straight from the source. Once the target is reached, the direct switch opens. The first fall below the target hands the load to block 1. After that, each new fall below the target, provided a rise came before it, swaps the load to the other, freshly charged block. If the output drops below the minimum while a block is feeding the load, the controller falls back to direct charging and emits a one-cycle heavy-load pulse. A two-bit step-down ratio selection is captured only during direct charging and passed on unchanged. Both comparator flags pass through a two-stage synchronizer before any decision uses them. A change at the inputs therefore reaches the switch outputs on the third rising clock edge after it.

Top module: `swc_ctrl`

States and transitions: CHARGE (switches 100) goes to IDLE (000) when both flags are high. IDLE goes to BLOCK1 (010) when the upper flag is low. BLOCK1 and BLOCK2 (001) swap on an armed falling crossing of the upper flag. Either block returns to CHARGE when the lower flag is low. The swap and the return each insert one break cycle in which all switches are off.

## Requirements
- R1: After reset the switches read direct=1, blk1=0, blk2=0, the phase code is 00, the ratio code is 00 and the heavy pulse is low.
- R2: At most one switch enable is high in any cycle, and the switch triple {direct,blk1,blk2} only ever takes 100, 000, 010 or 001.
- R3: In CHARGE, when the synchronized upper and lower flags are both 1, the phase becomes IDLE (code 01) and all switches turn off. IDLE is entered only from CHARGE.
- R4: In IDLE, when the synchronized upper flag is 0, the phase becomes BLOCK1 (code 10) with switches 010. The block 1 swap arm starts cleared.
- R5: In a block phase, a rising crossing of the upper flag arms a swap. The next falling crossing then moves the load to the other block (BLOCK1 code 10 and BLOCK2 code 11) and clears the arm. An upper flag that stays low, or a fall without a rise before it, causes no swap.
- R6: Every change from one non-zero switch code to another is separated by exactly one cycle of 000. During that cycle the phase code already shows the destination, and no flags are evaluated.
- R7: In a block phase with the synchronized lower flag at 0, the phase returns to CHARGE and the heavy output is high for exactly that one break cycle. This return takes priority over a swap.
- R8: The ratio output (00 = 1/1, 01 = 2/3, 10 = 1/2, 11 = 1/3) loads the ratio input on each clock while the switches read 100, and holds its value in every other cycle.
- R9: An input change affects the outputs on the third rising clock edge after it, through two synchronizer stages and the phase register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| above_hi_i | input | 1 | Comparator: output above upper threshold (asynchronous) |
| above_lo_i | input | 1 | Comparator: output above lower threshold (asynchronous) |
| ratio_sel_i | input | 2 | Requested step-down ratio code |
| sw_direct_o | output | 1 | Direct source switch enable |
| sw_blk1_o | output | 1 | Conversion block 1 to load enable |
| sw_blk2_o | output | 1 | Conversion block 2 to load enable |
| ratio_o | output | 2 | Latched ratio code for the block decoders |
| phase_o | output | 2 | Phase code: 00 CHARGE, 01 IDLE, 10 BLOCK1, 11 BLOCK2 |
| heavy_evt_o | output | 1 | One-cycle pulse on each forced return to CHARGE |

## Verification
The assertions assume that the comparator never reports the output above the upper threshold while it is below the lower threshold. They also assume that reset is applied at time zero. The stimulus respects the first assumption by dropping the upper flag whenever the lower flag falls and by raising the lower flag before the upper flag. It walks through charge, idle, a non-swapping long dip, alternation and heavy-load fallback. A long pseudo-random stretch then moves the output level up and down in small steps, so the flags cross in both directions, including crossings that land inside break cycles.

// File: rtl/swc_pkg.sv
package swc_pkg;
    typedef enum logic [1:0] {
        PH_CHARGE = 2'b00,
        PH_IDLE   = 2'b01,
        PH_BLK1   = 2'b10,
        PH_BLK2   = 2'b11
    } phase_t;

    localparam int SW_W = 3;

    // switch triple ordered {direct, blk1, blk2}
    function automatic logic [SW_W-1:0] phase_switches(input phase_t ph);
        unique case (ph)
            PH_CHARGE: return 3'b100;
            PH_IDLE:   return 3'b000;
            PH_BLK1:   return 3'b010;
            PH_BLK2:   return 3'b001;
        endcase
    endfunction
endpackage

// File: rtl/swc_sync.sv
module swc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
        end
        assign sync_o[b] = chain_q[LAST];
    end
endmodule

// File: rtl/swc_ratio.sv
module swc_ratio #(
    parameter int RW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [RW-1:0] sel_i,
    output logic [RW-1:0] ratio_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ratio_o <= '0;
        else if (load_i) ratio_o <= sel_i;
    end

    assert_ratio_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load_i) |-> $stable(ratio_o));
endmodule

// File: rtl/swc_seq.sv
module swc_seq
    import swc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hi_s,
    input  logic            lo_s,
    output phase_t          phase_o,
    output logic [SW_W-1:0] sw_o,
    output logic            heavy_o,
    output logic            charging_o
);
    phase_t phase_q, phase_d;
    logic   gap_q, gap_d;
    logic   armed_q, armed_d;
    logic   hi_d_q;
    logic   heavy_q, heavy_d;

    wire fall_hi = hi_d_q & ~hi_s;
    wire rise_hi = ~hi_d_q & hi_s;

    // next-state decisions
    always_comb begin
        phase_d = phase_q;
        gap_d   = 1'b0;
        armed_d = armed_q;
        heavy_d = 1'b0;
        if (!gap_q) begin
            unique case (phase_q)
                PH_CHARGE: if (hi_s && lo_s) phase_d = PH_IDLE;
                PH_IDLE: if (!hi_s) begin
                    phase_d = PH_BLK1;
                    armed_d = 1'b0;
                end
                PH_BLK1, PH_BLK2: begin
                    if (!lo_s) begin
                        phase_d = PH_CHARGE;
                        gap_d   = 1'b1;
                        heavy_d = 1'b1;
                        armed_d = 1'b0;
                    end else if (armed_q && fall_hi) begin
                        phase_d = (phase_q == PH_BLK1) ? PH_BLK2 : PH_BLK1;
                        gap_d   = 1'b1;
                        armed_d = 1'b0;
                    end else if (rise_hi) begin
                        armed_d = 1'b1;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_CHARGE;
            gap_q   <= 1'b0;
            armed_q <= 1'b0;
            hi_d_q  <= 1'b0;
            heavy_q <= 1'b0;
        end else begin
            phase_q <= phase_d;
            gap_q   <= gap_d;
            armed_q <= armed_d;
            hi_d_q  <= hi_s;
            heavy_q <= heavy_d;
        end
    end

    // outputs
    always_comb begin
        phase_o    = phase_q;
        sw_o       = gap_q ? '0 : phase_switches(phase_q);
        heavy_o    = heavy_q;
        charging_o = (phase_q == PH_CHARGE) && !gap_q;
    end

    assert_onehot_switch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sw_o));
    assert_break_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|sw_o && |$past(sw_o)) |-> sw_o == $past(sw_o));
    assert_idle_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_IDLE && $past(phase_o) != PH_IDLE) |-> $past(phase_o) == PH_CHARGE);
    assert_heavy_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        heavy_o |=> !heavy_o);
    assert_heavy_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        heavy_o |-> (phase_o == PH_CHARGE && sw_o == '0 && $past(phase_o[1])));
endmodule

// File: rtl/swc_ctrl.sv
module swc_ctrl
    import swc_pkg::*;
#(
    parameter int RATIO_W     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               above_hi_i,
    input  logic               above_lo_i,
    input  logic [RATIO_W-1:0] ratio_sel_i,
    output logic               sw_direct_o,
    output logic               sw_blk1_o,
    output logic               sw_blk2_o,
    output logic [RATIO_W-1:0] ratio_o,
    output logic [1:0]         phase_o,
    output logic               heavy_evt_o
);
    logic [1:0]      flags_s;
    logic [SW_W-1:0] sw;
    logic            charging;
    phase_t          phase;

    swc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({above_hi_i, above_lo_i}),
        .sync_o(flags_s)
    );

    swc_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .hi_s(flags_s[1]), .lo_s(flags_s[0]),
        .phase_o(phase), .sw_o(sw),
        .heavy_o(heavy_evt_o), .charging_o(charging)
    );

    swc_ratio #(.RW(RATIO_W)) u_ratio (
        .clk(clk), .rst_n(rst_n),
        .load_i(charging), .sel_i(ratio_sel_i),
        .ratio_o(ratio_o)
    );

    assign {sw_direct_o, sw_blk1_o, sw_blk2_o} = sw;
    assign phase_o = phase;

    assert_charge_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        charging |-> {sw_direct_o, sw_blk1_o, sw_blk2_o} == 3'b100);
endmodule

// File: tb/swc_ctrl_tb.sv
module swc_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hi = 1'b0, lo = 1'b0;
    logic [1:0] sel = 2'b00;
    logic       s0, s1, s2, heavy;
    logic [1:0] ratio, phase;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    swc_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .above_hi_i(hi), .above_lo_i(lo), .ratio_sel_i(sel),
        .sw_direct_o(s0), .sw_blk1_o(s1), .sw_blk2_o(s2),
        .ratio_o(ratio), .phase_o(phase), .heavy_evt_o(heavy)
    );

    // behavioural reference: delay lines as queues of past samples
    int q_hi[$], q_lo[$];
    int m_ph, m_gap, m_arm, m_heavy, m_ratio, m_prev_hi;

    function automatic int exp_sw(int ph, int gp);
        if (gp != 0) return 0;
        case (ph)
            0: return 4;
            1: return 0;
            2: return 2;
            default: return 1;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            q_hi = '{0, 0}; q_lo = '{0, 0};
            m_ph = 0; m_gap = 0; m_arm = 0; m_heavy = 0; m_ratio = 0; m_prev_hi = 0;
        end else begin
            int hs, ls, oph, ogap;
            hs = q_hi[0]; ls = q_lo[0]; oph = m_ph; ogap = m_gap;
            m_heavy = 0;
            m_gap = 0;
            if (ogap == 0) begin
                if (oph == 0) begin
                    if (hs != 0 && ls != 0) m_ph = 1;
                end else if (oph == 1) begin
                    if (hs == 0) begin m_ph = 2; m_arm = 0; end
                end else begin
                    if (ls == 0) begin
                        m_ph = 0; m_gap = 1; m_heavy = 1; m_arm = 0;
                    end else if (m_arm != 0 && m_prev_hi != 0 && hs == 0) begin
                        m_ph = (oph == 2) ? 3 : 2; m_gap = 1; m_arm = 0;
                    end else if (m_prev_hi == 0 && hs != 0) begin
                        m_arm = 1;
                    end
                end
            end
            if (oph == 0 && ogap == 0) m_ratio = int'(sel);
            m_prev_hi = hs;
            void'(q_hi.pop_front()); q_hi.push_back(int'(hi));
            void'(q_lo.pop_front()); q_lo.push_back(int'(lo));
        end
    end

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // compare against the model on every clock, away from the edge
    always @(negedge clk) begin
        if (rst_n) begin
            check("R2/R6 switches", int'({s0, s1, s2}), exp_sw(m_ph, m_gap));
            check("R9 phase", int'(phase), m_ph);
            check("R7 heavy", int'(heavy), m_heavy);
            check("R8 ratio", int'(ratio), m_ratio);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    int level;

    initial begin
        fork
            begin
                cyc(3);
                check("R1 reset switches", int'({s0, s1, s2}), 4);
                check("R1 reset phase", int'(phase), 0);
                check("R1 reset ratio", int'(ratio), 0);
                check("R1 reset heavy", int'(heavy), 0);
                rst_n = 1'b1;
                sel = 2'b10; cyc(4);
                check("R8 ratio loads in charge", int'(ratio), 2);
                lo = 1'b1; cyc(4);
                check("R3 stays charging on lower only", int'(phase), 0);
                hi = 1'b1;
                cyc(2);
                check("R9 no change after two edges", int'(phase), 0);
                cyc(1);
                check("R3 idle after third edge", int'(phase), 1);
                check("R3 switches off", int'({s0, s1, s2}), 0);
                sel = 2'b01; cyc(3);
                check("R8 ratio held outside charge", int'(ratio), 2);
                hi = 1'b0; cyc(4);
                check("R4 block1 on upper fall", int'({s0, s1, s2}), 2);
                cyc(20);
                check("R5 no swap on long dip", int'(phase), 2);
                hi = 1'b1; cyc(4); hi = 1'b0;
                cyc(3);
                check("R6 break cycle", int'({s0, s1, s2}), 0);
                check("R6 phase shows target", int'(phase), 3);
                cyc(1);
                check("R5 block2 after swap", int'({s0, s1, s2}), 1);
                hi = 1'b1; cyc(4); hi = 1'b0; cyc(5);
                check("R5 back to block1", int'(phase), 2);
                lo = 1'b0; cyc(3);
                check("R7 heavy pulse", int'(heavy), 1);
                check("R7 phase charge", int'(phase), 0);
                cyc(1);
                check("R7 direct on", int'({s0, s1, s2}), 4);
                check("R7 pulse single", int'(heavy), 0);
                // pseudo-random output level: 0 below lower, 1 between, 2 above upper
                level = 0;
                for (int i = 0; i < 6000; i++) begin
                    int r;
                    r = $urandom_range(0, 9);
                    if (r == 0 && level > 0) level--;
                    else if (r == 1 && level < 2) level++;
                    lo = (level >= 1);
                    hi = (level == 2);
                    if ($urandom_range(0, 15) == 0) sel = 2'($urandom_range(0, 3));
                    cyc(1);
                end
                cyc(5);
            end
            begin
                repeat (WATCHDOG) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule